// File: doc/BRIEF.md
# Canonical Virtual Address Checker

This block screens each memory reference before it leaves the address generation stage. It takes a 64-bit virtual start address, an access size code and a marker that says whether the reference goes through the stack segment. It works out the address of the last byte of the access. It then tests both end bytes against the canonical-form rule for the configured number of implemented virtual address bits. An address is canonical when every bit from the top implemented bit up to bit 63 carries one value.

One clock after a request, exactly one verdict flag is raised. The verdict is either pass, a general-protection fault, or a stack fault. The fault kind follows the segment marker. A separate flag, raised in the same cycle, reports that every byte of the access lies at or below 0x7FFF_FFFF. Such an access can be held in a 32-bit pointer without any sign ambiguity.

The implemented width is a parameter. It defaults to 48 bits, and 57 bits gives the deeper paging mode. The flags are registered, so they can feed the fault logic of the next pipeline stage directly.

Top module: `vaddr_canon_check`

## Requirements
- R1: While reset (`rst_n` low) is applied, and in the first cycle after it, all four output flags are 0.
- R2: One cycle after a cycle with `req_valid` low, all four output flags are 0.
- R3: With IMPL_BITS implemented bits, an address is canonical exactly when bits 63 down to IMPL_BITS-1 are all 0 or all 1. For 48 bits the legal spans are 0x0000_0000_0000_0000..0x0000_7FFF_FFFF_FFFF and 0xFFFF_8000_0000_0000..0xFFFF_FFFF_FFFF_FFFF.
- R4: `req_size` encodes the byte count as a power of two: code 0 means 1 byte, 1 means 2, 2 means 4, 3 means 8, 4 means 16. Codes 5, 6 and 7 are treated as 16 bytes. The last byte address is start + bytes - 1, taken modulo 2^64.
- R5: `chk_pass` is 1 one cycle after a request only when both the start byte and the last byte are canonical. A non-canonical start or a non-canonical last byte makes the access fault.
- R6: A faulting access raises `chk_stack_fault` when `req_stack` was 1, and `chk_gp_fault` when `req_stack` was 0.
- R7: One cycle after a cycle with `req_valid` high, exactly one of `chk_pass`, `chk_gp_fault` and `chk_stack_fault` is 1.
- R8: `chk_trunc_ok` is 1 one cycle after a request exactly when the start and last byte addresses both have their upper 33 bits at zero, that is, both are at most 0x7FFF_FFFF.
- R9: An access whose last byte wraps past 0xFFFF_FFFF_FFFF_FFFF to low addresses passes when both end bytes are canonical.
- R10: Setting IMPL_BITS to 57 moves the canonical boundary to bit 56. For example, 0x0000_8000_0000_0000 is canonical at 57 bits and not at 48 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A reference is presented this cycle |
| req_addr | input | 64 | Virtual address of the first byte |
| req_size | input | 3 | Log2 of the access size in bytes (R4) |
| req_stack | input | 1 | Reference uses the stack segment |
| chk_pass | output | 1 | Both end bytes canonical |
| chk_gp_fault | output | 1 | Non-canonical, non-stack reference |
| chk_stack_fault | output | 1 | Non-canonical stack reference |
| chk_trunc_ok | output | 1 | All bytes at or below 0x7FFF_FFFF |

## Verification
The assertions assume that the request inputs hold known values in every cycle outside reset, including the cycles where `req_valid` is low. They also assume that `req_size` codes above 4 are legal, because they decode as 16 bytes. The bench meets these assumptions by driving all request inputs to defined values on every falling edge, starting before reset is released. It mixes directed end-of-range addresses with random addresses drawn near the canonical and 31-bit boundaries, and it sweeps all eight size codes. The same stimulus goes to a 48-bit and a 57-bit instance, so each boundary is exercised under both widths.

// File: rtl/vac_pkg.sv
package vac_pkg;

    localparam int SIZE_W  = 3;
    localparam int MAX_LOG = 4;

    typedef struct packed {
        logic pass;
        logic gp_fault;
        logic ss_fault;
        logic trunc_ok;
    } vac_flags_t;

endpackage

// File: rtl/vac_last_byte.sv
module vac_last_byte #(
    parameter int ADDR_W  = 64,
    parameter int SIZE_W  = 3,
    parameter int MAX_LOG = 4
) (
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [SIZE_W-1:0] size_code,
    output logic [ADDR_W-1:0] last_addr
);
    logic [SIZE_W-1:0] log_eff;
    logic [ADDR_W-1:0] span;

    always_comb begin
        // codes above the largest size clamp to it
        log_eff = (size_code > SIZE_W'(MAX_LOG)) ? SIZE_W'(MAX_LOG) : size_code;
        span    = (ADDR_W'(1) << log_eff) - ADDR_W'(1);
        // modulo 2^ADDR_W: a carry out of the top bit is dropped
        last_addr = first_addr + span;
    end
endmodule

// File: rtl/vac_canon.sv
module vac_canon #(
    parameter int HI_W = 17
) (
    input  logic [HI_W-1:0] hi_bits,
    output logic            canon
);
    // all upper bits equal: either none set or all set
    assign canon = (&hi_bits) | ~(|hi_bits);
endmodule

// File: rtl/vac_low_window.sv
module vac_low_window #(
    parameter int HI_W = 33
) (
    input  logic [HI_W-1:0] hi_bits,
    output logic            in_window
);
    assign in_window = ~(|hi_bits);
endmodule

// File: rtl/vaddr_canon_check.sv
module vaddr_canon_check
    import vac_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int IMPL_BITS  = 48,
    parameter int TRUNC_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic                 req_stack,
    output logic                 chk_pass,
    output logic                 chk_gp_fault,
    output logic                 chk_stack_fault,
    output logic                 chk_trunc_ok
);
    localparam int CANON_HI_W = ADDR_W - IMPL_BITS + 1;
    localparam int TRUNC_HI_W = ADDR_W - TRUNC_BITS + 1;
    localparam int N_ENDS     = 2;

    logic [ADDR_W-1:0] last_addr;
    logic [ADDR_W-1:0] end_addr [N_ENDS];
    logic [N_ENDS-1:0] end_canon;
    logic [N_ENDS-1:0] end_low;

    vac_flags_t flags_d, flags_q;

    vac_last_byte #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .MAX_LOG(MAX_LOG)
    ) u_last (
        .first_addr(req_addr),
        .size_code (req_size),
        .last_addr (last_addr)
    );

    assign end_addr[0] = req_addr;
    assign end_addr[1] = last_addr;

    for (genvar e = 0; e < N_ENDS; e++) begin : g_end
        vac_canon #(
            .HI_W(CANON_HI_W)
        ) u_canon (
            .hi_bits(end_addr[e][ADDR_W-1:IMPL_BITS-1]),
            .canon  (end_canon[e])
        );

        vac_low_window #(
            .HI_W(TRUNC_HI_W)
        ) u_low (
            .hi_bits  (end_addr[e][ADDR_W-1:TRUNC_BITS-1]),
            .in_window(end_low[e])
        );
    end

    always_comb begin
        logic ok;
        flags_d = '0;
        ok      = &end_canon;
        if (req_valid) begin
            flags_d.pass     = ok;
            flags_d.gp_fault = !ok && !req_stack;
            flags_d.ss_fault = !ok &&  req_stack;
            flags_d.trunc_ok = &end_low;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign chk_pass        = flags_q.pass;
    assign chk_gp_fault    = flags_q.gp_fault;
    assign chk_stack_fault = flags_q.ss_fault;
    assign chk_trunc_ok    = flags_q.trunc_ok;

endmodule

// File: rtl/vac_checker.sv
module vac_checker #(
    parameter int ADDR_W     = 64,
    parameter int IMPL_BITS  = 48,
    parameter int TRUNC_BITS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [2:0]        req_size,
    input logic              req_stack,
    input logic              chk_pass,
    input logic              chk_gp_fault,
    input logic              chk_stack_fault,
    input logic              chk_trunc_ok
);
    logic start_canon;
    logic start_high;
    logic unused_lo;

    assign start_canon = (&req_addr[ADDR_W-1:IMPL_BITS-1]) | ~(|req_addr[ADDR_W-1:IMPL_BITS-1]);
    assign start_high  = |req_addr[ADDR_W-1:TRUNC_BITS-1];
    assign unused_lo   = &{1'b0, req_addr[TRUNC_BITS-2:0]};

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> $countones({chk_pass, chk_gp_fault, chk_stack_fault}) == 1); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(chk_pass || chk_gp_fault || chk_stack_fault || chk_trunc_ok)); // R2
    AST_STACK_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_stack |=> !chk_gp_fault); // R6
    AST_GP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_stack |=> !chk_stack_fault); // R6
    AST_BAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !start_canon |=> !chk_pass); // R5
    AST_BYTE_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_size == 3'd0) && start_canon |=> chk_pass); // R3
    AST_TRUNC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && start_high |=> !chk_trunc_ok); // R8
    AST_TRUNC_IMPLIES_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_trunc_ok |-> chk_pass); // R8
endmodule

bind vaddr_canon_check vac_checker #(
    .ADDR_W    (ADDR_W),
    .IMPL_BITS (IMPL_BITS),
    .TRUNC_BITS(TRUNC_BITS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_size       (req_size),
    .req_stack      (req_stack),
    .chk_pass       (chk_pass),
    .chk_gp_fault   (chk_gp_fault),
    .chk_stack_fault(chk_stack_fault),
    .chk_trunc_ok   (chk_trunc_ok)
);

// File: tb/vaddr_canon_check_test.sv
module vaddr_canon_check_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic        req_stack = 1'b0;
    logic        p48, g48, s48, t48;
    logic        p57, g57, s57, t57;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vaddr_canon_check #(.IMPL_BITS(48)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_stack(req_stack), .chk_pass(p48),
        .chk_gp_fault(g48), .chk_stack_fault(s48), .chk_trunc_ok(t48));

    vaddr_canon_check #(.IMPL_BITS(57)) uut_w (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_stack(req_stack), .chk_pass(p57),
        .chk_gp_fault(g57), .chk_stack_fault(s57), .chk_trunc_ok(t57));

    function automatic bit is_canon(logic [63:0] a, int impl);
        logic [63:0] hi;
        logic [63:0] ones;
        hi   = a >> (impl - 1);
        ones = (64'd1 << (65 - impl)) - 64'd1;
        return (hi == 64'd0) || (hi == ones);
    endfunction

    function automatic logic [63:0] last_of(logic [63:0] a, logic [2:0] code);
        int lg;
        lg = (code > 3'd4) ? 4 : int'(code);
        return a + (64'd1 << lg) - 64'd1;
    endfunction

    function automatic logic [3:0] model(bit v, logic [63:0] a, logic [2:0] code,
                                         bit stk, int impl);
        logic [63:0] l;
        bit ok, lo;
        if (!v) return 4'b0000;
        l  = last_of(a, code);
        ok = is_canon(a, impl) && is_canon(l, impl);
        lo = ((a >> 31) == 64'd0) && ((l >> 31) == 64'd0);
        return {ok, !ok && !stk, !ok && stk, lo};
    endfunction

    task automatic compare(string tag, logic [3:0] got, logic [3:0] exp, int impl);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s impl=%0d addr=%h size=%0d stk=%0b got pass/gp/ss/tr=%b expected %b",
                     tag, impl, req_addr, req_size, req_stack, got, exp);
        end
    endtask

    task automatic step(string tag, bit v, logic [63:0] a, logic [2:0] code, bit stk);
        logic [3:0] e48, e57;
        req_valid = v;
        req_addr  = a;
        req_size  = code;
        req_stack = stk;
        e48 = model(v, a, code, stk, 48);
        e57 = model(v, a, code, stk, 57);
        @(posedge clk);
        @(negedge clk);
        compare(tag, {p48, g48, s48, t48}, e48, 48);
        compare(tag, {p57, g57, s57, t57}, e57, 57);
        checks++;
        if ($countones({p48, g48, s48}) != int'(v)) begin
            errors++;
            $display("FAIL R7 verdict count got %0d expected %0d",
                     $countones({p48, g48, s48}), int'(v));
        end
    endtask

    function automatic logic [63:0] pick_addr();
        logic [63:0] r;
        r = {$urandom, $urandom};
        case ($urandom_range(0, 5))
            0: return 64'h0000_7FFF_FFFF_FFF0 + {60'd0, r[3:0]};
            1: return 64'hFFFF_7FFF_FFFF_FFF8 + {60'd0, r[3:0]};
            2: return 64'h0000_0000_7FFF_FFF8 + {60'd0, r[3:0]};
            3: return 64'hFFFF_FFFF_FFFF_FFF0 + {60'd0, r[3:0]};
            4: return 64'h00FF_FFFF_FFFF_FFF8 + {60'd0, r[3:0]};
            default: return r;
        endcase
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: flags low under reset
        compare("R1", {p48, g48, s48, t48}, 4'b0000, 48);
        compare("R1", {p57, g57, s57, t57}, 4'b0000, 57);
        rst_n = 1'b1;
        step("R1", 1'b0, 64'd0, 3'd0, 1'b0);
        step("R2", 1'b0, 64'h0000_8000_0000_0000, 3'd4, 1'b1);
        step("R3", 1'b1, 64'd0, 3'd0, 1'b0);
        step("R8", 1'b1, 64'h0000_0000_7FFF_FFFF, 3'd0, 1'b0);
        step("R8", 1'b1, 64'h0000_0000_7FFF_FFFF, 3'd1, 1'b0);
        step("R8", 1'b1, 64'h0000_0000_8000_0000, 3'd0, 1'b0);
        step("R3", 1'b1, 64'h0000_7FFF_FFFF_FFFF, 3'd0, 1'b0);
        step("R5", 1'b1, 64'h0000_7FFF_FFFF_FFFF, 3'd1, 1'b0);
        step("R6", 1'b1, 64'h0000_7FFF_FFFF_FFFF, 3'd1, 1'b1);
        step("R10", 1'b1, 64'h0000_8000_0000_0000, 3'd0, 1'b0);
        step("R3", 1'b1, 64'hFFFF_8000_0000_0000, 3'd3, 1'b0);
        step("R5", 1'b1, 64'hFFFF_7FFF_FFFF_FFF8, 3'd4, 1'b1);
        step("R9", 1'b1, 64'hFFFF_FFFF_FFFF_FFF8, 3'd4, 1'b0);
        step("R4", 1'b1, 64'h0000_7FFF_FFFF_FFF8, 3'd7, 1'b0);
        step("R4", 1'b1, 64'h0000_7FFF_FFFF_FFF8, 3'd3, 1'b0);
        step("R4", 1'b1, 64'h0000_7FFF_FFFF_FFF8, 3'd5, 1'b1);
        step("R10", 1'b1, 64'h0100_0000_0000_0000, 3'd0, 1'b1);
        step("R10", 1'b1, 64'h00FF_FFFF_FFFF_FFF8, 3'd4, 1'b0);
        step("R7", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 1'b1);
        for (int i = 0; i < 400; i++) begin
            step("R5", ($urandom_range(0, 3) != 0), pick_addr(),
                 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
        end
        step("R2", 1'b0, 64'd0, 3'd0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule